// File: doc/BRIEF.md
# Shared-Pin GPIO Port with Peripheral Ownership

This block is an eight-pin general purpose I/O port whose pads are shared with two on-chip peripherals: a pulse-width unit with one channel per pin, and a serial peripheral interface that uses the low four pins. For every pin a fixed priority picks the owner. An enabled pulse-width channel owns its pin first. The serial interface owns its pins next, while it is enabled. Otherwise the port's own data and direction registers drive the pin. The block produces the output value and output enable for each pad and receives the buffered pad inputs.

Software uses a small synchronous register bus with three registers. The data register is read-write. When a pin is set as an output, a data-register read returns the latched value. When the pin is set as an input, the read returns the live pad level instead. The pin register is read-only and always returns the sampled pad levels, whatever the direction or the owner of the pin. Software can compare this register with what it drives to find a shorted or overloaded output.

The pin register is held at zero while reset is active. A small sampling state machine then loads it. The machine has three states: `CAP_WAIT0` (entered on reset), `CAP_WAIT1` and `CAP_TRACK`. It makes the transition `CAP_WAIT0`→`CAP_WAIT1` on the first clock edge after reset is released. It makes `CAP_WAIT1`→`CAP_TRACK` on the second edge, which loads the pad levels. In `CAP_TRACK` it stays put and reloads the pad levels on every edge.

Top module: `gpio_mux_port`

## Requirements
- R1: After reset the data and direction registers read 0, the pin register reads 0, and with no peripheral enabled every `pad_oe` bit is 0.
- R2: A bus write (`wr_en`=1) to address 0 (data) or address 2 (direction) is visible on `rd_data` at that address from the next clock cycle. Reads are combinational on `addr`.
- R3: A data-register read returns `data` for each pin whose direction bit is 1, and `pad_in` for each pin whose direction bit is 0.
- R4: A pin owned by neither peripheral has `pad_oe` equal to its direction bit and `pad_out` equal to its data bit.
- R5: When `pwm_en[i]` is 1 for i in 0..6, that pin has `pad_oe`=1 and `pad_out`=`pwm_out[i]`, whatever the serial interface and port registers hold.
- R6: When `pwm_en[7]` is 1, pin 7 drives `pwm_out[7]` with `pad_oe`=1 if `pwm_shdn_en` is 0. If `pwm_shdn_en` is 1, pin 7 is an input with `pad_oe`=0 and `pad_out`=0.
- R7: When `spi_en` is 1, each pin 0..3 whose pulse-width channel is off takes `pad_oe` from `spi_oe` and `pad_out` from `spi_out`. The bit mapping is: bit 0 receive-out (MISO), bit 1 transmit-out (MOSI), bit 2 serial clock, bit 3 select.
- R8: Pins 4..7 are never owned by the serial interface. With their pulse-width channels off, they follow the port registers whatever the value of `spi_en`.
- R9: The pin register reads 0 until two clock edges after reset release. From the second edge on it holds the `pad_in` value sampled at the most recent edge.
- R10: Writes to address 1 (pin register) and address 3 (unused) change no register. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register select: 0 data, 1 pin, 2 direction |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` |
| pwm_en | input | 8 | Per-channel pulse-width enable |
| pwm_out | input | 8 | Per-channel pulse-width output level |
| pwm_shdn_en | input | 1 | Channel 7 shutdown input mode |
| spi_en | input | 1 | Serial interface enable |
| spi_out | input | 4 | Serial interface drive levels, pins 0..3 |
| spi_oe | input | 4 | Serial interface output enables, pins 0..3 |
| pad_in | input | 8 | Buffered pad levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |

## Verification
The bench sets up the priority conflicts directly. In one case a pulse-width channel and the serial interface claim the same pin: a design with the priority reversed would let the serial enable override the pulse-width drive. In another the serial interface is enabled while pins 4..7 are set up for GPIO: a design that applied the serial mask too widely would override them. Channel 7 is tested with the shutdown mode both on and off, to catch a pin that keeps driving while it should be an input. The bench also checks the data read with mixed directions, where a design returning the register for every bit fails. It counts the exact edges before the pin register leaves zero, where a design loading one edge early or late fails. Writes to the read-only and unused addresses are tested too, to catch a decoder that lets them through.

// File: rtl/gpm_pkg.sv
package gpm_pkg;

    typedef enum logic [1:0] {
        REG_DATA = 2'd0,
        REG_PIN  = 2'd1,
        REG_DIR  = 2'd2
    } reg_sel_e;

    typedef enum logic [1:0] {
        CAP_WAIT0 = 2'd0,
        CAP_WAIT1 = 2'd1,
        CAP_TRACK = 2'd2
    } cap_state_e;

endpackage

// File: rtl/gpm_capture.sv
module gpm_capture
    import gpm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] pin_q,
    output cap_state_e   state
);

    cap_state_e state_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CAP_WAIT0;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            CAP_WAIT0: state_nx = CAP_WAIT1;
            CAP_WAIT1: state_nx = CAP_TRACK;
            CAP_TRACK: state_nx = CAP_TRACK;
            default:   state_nx = CAP_WAIT0;
        endcase
    end

    // output register: sampled pad levels
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q <= '0;
        end else begin
            unique case (state)
                CAP_WAIT0: pin_q <= '0;
                CAP_WAIT1: pin_q <= pad_in;
                CAP_TRACK: pin_q <= pad_in;
                default:   pin_q <= '0;
            endcase
        end
    end

endmodule

// File: rtl/gpm_regs.sv
module gpm_regs
    import gpm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   addr,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] pad_in,
    input  logic [W-1:0] pin_q,
    output logic [W-1:0] data_q,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] rd_data
);

    reg_sel_e sel;
    assign sel = reg_sel_e'(addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            dir_q  <= '0;
        end else if (wr_en) begin
            unique case (sel)
                REG_DATA: data_q <= wr_data;
                REG_DIR:  dir_q  <= wr_data;
                default:  ;
            endcase
        end
    end

    always_comb begin
        unique case (sel)
            REG_DATA: rd_data = (data_q & dir_q) | (pad_in & ~dir_q);
            REG_PIN:  rd_data = pin_q;
            REG_DIR:  rd_data = dir_q;
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/gpm_owner.sv
module gpm_owner #(
    parameter int W          = 8,
    parameter int SPI_PINS   = 4,
    parameter int PWM_IN_PIN = 7
) (
    input  logic [W-1:0]        data_q,
    input  logic [W-1:0]        dir_q,
    input  logic [W-1:0]        pwm_en,
    input  logic [W-1:0]        pwm_out,
    input  logic                pwm_shdn_en,
    input  logic                spi_en,
    input  logic [SPI_PINS-1:0] spi_out,
    input  logic [SPI_PINS-1:0] spi_oe,
    output logic [W-1:0]        pad_out,
    output logic [W-1:0]        pad_oe
);

    for (genvar i = 0; i < W; i++) begin : g_pin
        localparam bit CAN_SHDN = (i == PWM_IN_PIN);
        logic oe_b;
        logic out_b;

        if (i < SPI_PINS) begin : g_spi
            always_comb begin
                if (pwm_en[i]) begin
                    oe_b  = !(CAN_SHDN && pwm_shdn_en);
                    out_b = pwm_out[i] && !(CAN_SHDN && pwm_shdn_en);
                end else if (spi_en) begin
                    oe_b  = spi_oe[i];
                    out_b = spi_out[i];
                end else begin
                    oe_b  = dir_q[i];
                    out_b = data_q[i];
                end
            end
        end else begin : g_plain
            always_comb begin
                if (pwm_en[i]) begin
                    oe_b  = !(CAN_SHDN && pwm_shdn_en);
                    out_b = pwm_out[i] && !(CAN_SHDN && pwm_shdn_en);
                end else begin
                    oe_b  = dir_q[i];
                    out_b = data_q[i];
                end
            end
        end

        assign pad_oe[i]  = oe_b;
        assign pad_out[i] = out_b;
    end

endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
    import gpm_pkg::*;
#(
    parameter int W          = 8,
    parameter int SPI_PINS   = 4,
    parameter int PWM_IN_PIN = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          addr,
    input  logic                wr_en,
    input  logic [W-1:0]        wr_data,
    output logic [W-1:0]        rd_data,
    input  logic [W-1:0]        pwm_en,
    input  logic [W-1:0]        pwm_out,
    input  logic                pwm_shdn_en,
    input  logic                spi_en,
    input  logic [SPI_PINS-1:0] spi_out,
    input  logic [SPI_PINS-1:0] spi_oe,
    input  logic [W-1:0]        pad_in,
    output logic [W-1:0]        pad_out,
    output logic [W-1:0]        pad_oe
);

    logic [W-1:0] data_q;
    logic [W-1:0] dir_q;
    logic [W-1:0] pin_q;
    cap_state_e   cap_state;

    gpm_capture #(.W(W)) i_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_in (pad_in),
        .pin_q  (pin_q),
        .state  (cap_state)
    );

    gpm_regs #(.W(W)) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .pad_in  (pad_in),
        .pin_q   (pin_q),
        .data_q  (data_q),
        .dir_q   (dir_q),
        .rd_data (rd_data)
    );

    gpm_owner #(.W(W), .SPI_PINS(SPI_PINS), .PWM_IN_PIN(PWM_IN_PIN)) i_owner (
        .data_q      (data_q),
        .dir_q       (dir_q),
        .pwm_en      (pwm_en),
        .pwm_out     (pwm_out),
        .pwm_shdn_en (pwm_shdn_en),
        .spi_en      (spi_en),
        .spi_out     (spi_out),
        .spi_oe      (spi_oe),
        .pad_out     (pad_out),
        .pad_oe      (pad_oe)
    );

endmodule

// File: rtl/gpm_checker.sv
module gpm_checker
    import gpm_pkg::*;
#(
    parameter int W          = 8,
    parameter int SPI_PINS   = 4,
    parameter int PWM_IN_PIN = 7
) (
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          addr,
    input logic                wr_en,
    input logic [W-1:0]        wr_data,
    input logic [W-1:0]        pwm_en,
    input logic [W-1:0]        pwm_out,
    input logic                pwm_shdn_en,
    input logic                spi_en,
    input logic [SPI_PINS-1:0] spi_oe,
    input logic [W-1:0]        pad_in,
    input logic [W-1:0]        pad_out,
    input logic [W-1:0]        pad_oe,
    input logic [W-1:0]        dir_q,
    input logic [W-1:0]        pin_q,
    input cap_state_e          cap_state
);

    localparam logic [W-1:0] OUT_ONLY = ~(W'(1) << PWM_IN_PIN);
    localparam logic [W-1:0] SPI_MASK = W'((1 << SPI_PINS) - 1);

    p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_DIR) |=> dir_q == $past(wr_data));

    p_pwm_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (((pad_oe & pwm_en & OUT_ONLY) == (pwm_en & OUT_ONLY)) &&
         (((pad_out ^ pwm_out) & pwm_en & OUT_ONLY) == '0)));

    p_shdn_input_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_en[PWM_IN_PIN] && pwm_shdn_en) |-> !pad_oe[PWM_IN_PIN]);

    p_spi_oe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        spi_en |-> (((pad_oe ^ W'(spi_oe)) & ~pwm_en & SPI_MASK) == '0));

    p_upper_gpio_r8: assert property (@(posedge clk) disable iff (!rst_n)
        spi_en |-> (((pad_oe ^ dir_q) & ~pwm_en & ~SPI_MASK) == '0));

    p_pin_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_state != CAP_TRACK) |-> pin_q == '0);

    p_pin_track_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_state == CAP_TRACK) |=> pin_q == $past(pad_in));

    p_dir_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr != REG_DIR) |=> $stable(dir_q));

endmodule

bind gpio_mux_port gpm_checker #(.W(W), .SPI_PINS(SPI_PINS), .PWM_IN_PIN(PWM_IN_PIN)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr        (addr),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .pwm_en      (pwm_en),
    .pwm_out     (pwm_out),
    .pwm_shdn_en (pwm_shdn_en),
    .spi_en      (spi_en),
    .spi_oe      (spi_oe),
    .pad_in      (pad_in),
    .pad_out     (pad_out),
    .pad_oe      (pad_oe),
    .dir_q       (dir_q),
    .pin_q       (pin_q),
    .cap_state   (cap_state)
);

// File: tb/test_gpio_mux_port.sv
module test_gpio_mux_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = 2'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic [7:0] pwm_en = 8'h00;
    logic [7:0] pwm_out = 8'h00;
    logic       pwm_shdn_en = 1'b0;
    logic       spi_en = 1'b0;
    logic [3:0] spi_out = 4'h0;
    logic [3:0] spi_oe = 4'h0;
    logic [7:0] pad_in = 8'h00;
    logic [7:0] pad_out;
    logic [7:0] pad_oe;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpio_mux_port i_gpio_mux_port (
        .clk (clk), .rst_n (rst_n), .addr (addr), .wr_en (wr_en),
        .wr_data (wr_data), .rd_data (rd_data), .pwm_en (pwm_en),
        .pwm_out (pwm_out), .pwm_shdn_en (pwm_shdn_en), .spi_en (spi_en),
        .spi_out (spi_out), .spi_oe (spi_oe), .pad_in (pad_in),
        .pad_out (pad_out), .pad_oe (pad_oe)
    );

    typedef struct packed {
        logic [7:0] dir;
        logic [7:0] data;
        logic [7:0] pen;
        logic [7:0] pout;
        logic       shdn;
        logic       sen;
        logic [3:0] soe;
        logic [3:0] sout;
        logic [7:0] exp_oe;
        logic [7:0] exp_out;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t TBL [NV] = '{
        '{8'hF0, 8'hA5, 8'h00, 8'h00, 1'b0, 1'b0, 4'h0, 4'h0, 8'hF0, 8'hA5}, // R4 plain GPIO
        '{8'h00, 8'h00, 8'h7F, 8'h55, 1'b0, 1'b0, 4'h0, 4'h0, 8'h7F, 8'h55}, // R5 channels 0..6
        '{8'h00, 8'h00, 8'h80, 8'h80, 1'b0, 1'b0, 4'h0, 4'h0, 8'h80, 8'h80}, // R6 ch7 output
        '{8'h00, 8'h00, 8'h80, 8'h80, 1'b1, 1'b0, 4'h0, 4'h0, 8'h00, 8'h00}, // R6 ch7 shutdown input
        '{8'hFF, 8'h0F, 8'h00, 8'h00, 1'b0, 1'b1, 4'hE, 4'hA, 8'hFE, 8'h0A}, // R7 serial master
        '{8'h00, 8'hFF, 8'h06, 8'hFF, 1'b0, 1'b1, 4'h1, 4'h0, 8'h07, 8'hF6}, // R5 R7 priority
        '{8'hF0, 8'h30, 8'h00, 8'h00, 1'b0, 1'b1, 4'h0, 4'hF, 8'hF0, 8'h3F}  // R8 upper pins
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rd_data;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        pad_in = 8'h3C;
        repeat (3) @(negedge clk);
        // R1 values while held in reset
        chk("R1 pad_oe in reset", pad_oe, 8'h00);
        bus_rd(2'd1, r); chk("R1 pin reg in reset", r, 8'h00);
        rst_n = 1'b1;
        bus_rd(2'd2, r); chk("R1 dir after reset", r, 8'h00);
        bus_rd(2'd0, r); chk("R3 data read all inputs", r, 8'h3C);
        @(negedge clk);
        bus_rd(2'd1, r); chk("R9 pin reg one edge after reset", r, 8'h00);
        @(negedge clk);
        bus_rd(2'd1, r); chk("R9 pin reg two edges after reset", r, 8'h3C);

        // R9 tracking with one edge latency
        pad_in = 8'h81;
        #1;
        bus_rd(2'd1, r); chk("R9 pin reg before edge", r, 8'h3C);
        @(negedge clk);
        bus_rd(2'd1, r); chk("R9 pin reg after edge", r, 8'h81);

        // R2 writes, R3 mixed direction read
        bus_wr(2'd0, 8'hAA);
        bus_wr(2'd2, 8'h0F);
        bus_rd(2'd2, r); chk("R2 dir readback", r, 8'h0F);
        pad_in = 8'h55;
        bus_rd(2'd0, r); chk("R3 mixed direction read", r, 8'h5A);
        bus_wr(2'd2, 8'hFF);
        bus_rd(2'd0, r); chk("R2 data readback", r, 8'hAA);

        // R10 ignored writes
        pad_in = 8'h12;
        bus_wr(2'd1, 8'hFF);
        bus_rd(2'd1, r); chk("R10 pin reg write ignored", r, 8'h12);
        bus_wr(2'd3, 8'h00);
        bus_rd(2'd3, r); chk("R10 unused address reads 0", r, 8'h00);
        bus_rd(2'd0, r); chk("R10 data untouched", r, 8'hAA);
        bus_rd(2'd2, r); chk("R10 dir untouched", r, 8'hFF);

        // ownership table
        for (int k = 0; k < NV; k++) begin
            bus_wr(2'd2, TBL[k].dir);
            bus_wr(2'd0, TBL[k].data);
            pwm_en = TBL[k].pen;
            pwm_out = TBL[k].pout;
            pwm_shdn_en = TBL[k].shdn;
            spi_en = TBL[k].sen;
            spi_oe = TBL[k].soe;
            spi_out = TBL[k].sout;
            #2;
            chk($sformatf("ownership row %0d pad_oe (R4..R8)", k), pad_oe, TBL[k].exp_oe);
            chk($sformatf("ownership row %0d pad_out (R4..R8)", k), pad_out, TBL[k].exp_out);
        end

        // R8 upper pins identical with spi_en toggled
        spi_en = 1'b0;
        #2;
        chk("R8 upper oe without serial", pad_oe & 8'hF0, 8'hF0);
        chk("R8 upper out without serial", pad_out & 8'hF0, 8'h30);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule